// File: doc/BRIEF.md
# Serial audio sample receiver

This block takes a stereo PCM stream on three wires (a bit clock, a channel-select line and a serial data line) and turns it into parallel left and right samples. The three wires are synchronised into a faster system clock, and only rising bit-clock edges are acted on. A static select input chooses between two framings. The first is a 20-bit right-aligned layout, where each word ends on the last bit before the channel line toggles. The second is a 24-bit layout with a one-bit delay, where each word starts one bit after the toggle.

When both halves of a frame carry exactly 16 bit clocks, the block switches to 16-bit words for that frame, whichever framing is selected. Every half-frame is counted. The count of the most recent half is brought out, and a half that is too short for the active word length turns the frame into a framing error instead of a sample. Samples leave left-aligned in a 24-bit field, and the left and right words of a frame appear together with a single-cycle strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: Serial data is taken MSB first, and only the values present at a rising edge of the bit clock are used. Data and channel-line changes between rising edges have no effect.
- R2: With `fmt_i2s_i` = 0, the word is the last 20 bits of a half, ending with the bit taken on the last rising edge before the channel line toggles. Any earlier bits in the half are discarded. Channel line high marks the left channel.
- R3: With `fmt_i2s_i` = 1, the MSB is the bit taken on the second rising edge after a channel-line toggle, and channel line low marks the left channel. A half of 24 or more bits gives the first 24 of them, and later bits are discarded.
- R4: When both halves of a frame hold exactly 16 rising edges, 16-bit words are taken in either format, `short16_o` reads 1 with that frame, and the 8 low bits of both outputs are zero.
- R5: The two halves of a frame may differ in length. Any pair of halves that both meet the word length gives a valid frame.
- R6: If either half of a frame has fewer rising edges than the active word length (16, 20 or 24), `frame_err_o` pulses for one cycle instead of `valid_o`, and `left_o`/`right_o` keep their previous values.
- R7: `valid_o` is a one-cycle pulse that follows the end of the right half. It presents both words of that frame together, and the outputs do not change at any other time.
- R8: `half_bits_o` gives the number of rising edges in the most recently completed half. It updates once per half and saturates at 255.
- R9: After reset all outputs are zero. The partial half in progress before the first observed channel-line toggle, and a right half with no preceding left half, produce no output.
- R10: In 20-bit mode (`fmt_i2s_i` = 0) the 4 low output bits are zero. A frame where only one half holds 16 edges is not treated as 16-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i2s_i | input | 1 | Framing select: 0 right-aligned 20-bit, 1 delayed 24-bit |
| bclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Channel select line |
| sdata_i | input | 1 | Serial data |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| frame_err_o | output | 1 | One-cycle strobe for a frame with a short half |
| short16_o | output | 1 | The last valid frame used 16-bit words |
| half_bits_o | output | 8 | Rising-edge count of the last completed half |

## Verification
A half counter that is off by one shows up within one frame. The frame is either mis-sized into a spurious framing error, or it loses the 16-bit case, and either way `half_bits_o` reads wrong on the same strobe. A wrong shift window or a wrong channel polarity shifts or swaps the sample bits, and this appears at the next `valid_o`. A lost pairing state shows up as a missing or extra strobe against the queued expectations before the run ends.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  parameter int SAMPLE_W    = 24;
  parameter int CNT_W       = 8;
  parameter int RJ_LEN      = 20;
  parameter int I2S_LEN     = 24;
  parameter int SHORT_LEN   = 16;
  parameter int SYNC_STAGES = 2;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [CNT_W-1:0]    count_t;

  typedef struct packed {
    logic    lvl;
    count_t  cnt;
    sample_t raw;
  } half_t;

  function automatic count_t active_len(logic fmt_i2s, logic short_mode);
    if (short_mode) return count_t'(SHORT_LEN);
    return fmt_i2s ? count_t'(I2S_LEN) : count_t'(RJ_LEN);
  endfunction

  function automatic sample_t align_word(sample_t raw, count_t len);
    return raw << (count_t'(SAMPLE_W) - len);
  endfunction

  function automatic logic is_left(logic fmt_i2s, logic lvl);
    return fmt_i2s ? ~lvl : lvl;
  endfunction

  function automatic count_t sat_inc(count_t c);
    return (c == '1) ? c : c + 1'b1;
  endfunction
endpackage

// File: rtl/sarx_edge_sync.sv
module sarx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrck_i,
  input  logic sdata_i,
  output logic bit_stb,
  output logic bit_val,
  output logic ws_val
);
  logic [STAGES-1:0][2:0] pipe;
  logic [2:0]             synced;
  logic                   bclk_q;

  assign synced = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe   <= '0;
      bclk_q <= 1'b0;
    end else begin
      pipe   <= {pipe[STAGES-2:0], {bclk_i, lrck_i, sdata_i}};
      bclk_q <= synced[2];
    end
  end

  assign bit_stb = synced[2] & ~bclk_q;
  assign ws_val  = synced[1];
  assign bit_val = synced[0];
endmodule

// File: rtl/sarx_half_collect.sv
module sarx_half_collect
  import sarx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fmt_i2s,
  input  logic  bit_stb,
  input  logic  bit_val,
  input  logic  ws_val,
  output logic  half_done,
  output half_t half
);
  logic    ws_d, eff_prev, armed;
  logic [1:0] warm;
  count_t  cnt;
  sample_t sreg;
  logic    ws_eff, edge_seen, keep_bit;

  always_comb begin
    ws_eff    = fmt_i2s ? ws_d : ws_val;
    edge_seen = (warm == 2'd2) && (ws_eff != eff_prev);
    keep_bit  = !fmt_i2s || (cnt < count_t'(I2S_LEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_d      <= 1'b0;
      eff_prev  <= 1'b0;
      armed     <= 1'b0;
      warm      <= 2'd0;
      cnt       <= '0;
      sreg      <= '0;
      half_done <= 1'b0;
      half      <= '0;
    end else begin
      half_done <= 1'b0;
      if (bit_stb) begin
        ws_d     <= ws_val;
        eff_prev <= ws_eff;
        if (warm != 2'd2) warm <= warm + 2'd1;
        if (edge_seen) begin
          half_done <= armed;
          half      <= '{lvl: eff_prev, cnt: cnt, raw: sreg};
          armed     <= 1'b1;
          cnt       <= count_t'(1);
          sreg      <= {{(SAMPLE_W-1){1'b0}}, bit_val};
        end else begin
          cnt <= sat_inc(cnt);
          if (keep_bit) sreg <= {sreg[SAMPLE_W-2:0], bit_val};
        end
      end
    end
  end
endmodule

// File: rtl/sarx_frame_pair.sv
module sarx_frame_pair
  import sarx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fmt_i2s,
  input  logic    half_done,
  input  half_t   half,
  output logic    pair_done,
  output sample_t left_o,
  output sample_t right_o,
  output logic    valid_o,
  output logic    frame_err_o,
  output logic    short16_o,
  output count_t  half_bits_o
);
  logic   have_left, cur_left, short_mode, long_enough;
  half_t  left_hold;
  count_t len;

  always_comb begin
    cur_left    = is_left(fmt_i2s, half.lvl);
    short_mode  = (left_hold.cnt == count_t'(SHORT_LEN)) &&
                  (half.cnt == count_t'(SHORT_LEN));
    len         = active_len(fmt_i2s, short_mode);
    long_enough = (left_hold.cnt >= len) && (half.cnt >= len);
    pair_done   = half_done && !cur_left && have_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_left   <= 1'b0;
      left_hold   <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      short16_o   <= 1'b0;
      half_bits_o <= '0;
    end else begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      if (half_done) begin
        half_bits_o <= half.cnt;
        if (cur_left) begin
          left_hold <= half;
          have_left <= 1'b1;
        end else begin
          have_left <= 1'b0;
        end
      end
      if (pair_done) begin
        if (long_enough) begin
          valid_o   <= 1'b1;
          left_o    <= align_word(left_hold.raw, len);
          right_o   <= align_word(half.raw, len);
          short16_o <= short_mode;
        end else begin
          frame_err_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_i2s_i,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                frame_err_o,
  output logic                short16_o,
  output logic [CNT_W-1:0]    half_bits_o
);
  logic  bit_stb, bit_val, ws_val;
  logic  half_done, pair_done;
  half_t half;

  sarx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrck_i(lrck_i),
    .sdata_i(sdata_i), .bit_stb(bit_stb), .bit_val(bit_val), .ws_val(ws_val)
  );

  sarx_half_collect u_half (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s_i), .bit_stb(bit_stb),
    .bit_val(bit_val), .ws_val(ws_val), .half_done(half_done), .half(half)
  );

  sarx_frame_pair u_pair (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s_i), .half_done(half_done),
    .half(half), .pair_done(pair_done), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .frame_err_o(frame_err_o), .short16_o(short16_o),
    .half_bits_o(half_bits_o)
  );
endmodule

// File: rtl/sarx_checker.sv
module sarx_checker
  import sarx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                fmt_i2s_i,
  input logic                bit_stb,
  input logic                half_done,
  input logic                pair_done,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                valid_o,
  input logic                frame_err_o,
  input logic                short16_o,
  input logic [CNT_W-1:0]    half_bits_o
);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !frame_err_o);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o || frame_err_o) |-> $past(pair_done));

  assert_half_after_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |-> $past(bit_stb));

  assert_pad16_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && short16_o) |->
      (left_o[SAMPLE_W-SHORT_LEN-1:0] == '0 && right_o[SAMPLE_W-SHORT_LEN-1:0] == '0));

  assert_pad20_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !fmt_i2s_i) |->
      (left_o[SAMPLE_W-RJ_LEN-1:0] == '0 && right_o[SAMPLE_W-RJ_LEN-1:0] == '0));

  assert_count_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(half_done) |-> $stable(half_bits_o));
endmodule

bind serial_audio_rx sarx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_i2s_i(fmt_i2s_i), .bit_stb(bit_stb),
  .half_done(half_done), .pair_done(pair_done), .left_o(left_o),
  .right_o(right_o), .valid_o(valid_o), .frame_err_o(frame_err_o),
  .short16_o(short16_o), .half_bits_o(half_bits_o)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, fmt = 1'b0;
  logic bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic valid_o, frame_err_o, short16_o;
  logic [7:0] half_bits_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  typedef struct { bit lvl; bit d; } ent_t;
  typedef struct { bit err; logic [23:0] l, r; bit sh; int hb; string tag; } exp_t;
  ent_t ents[$];
  exp_t sb[$];
  logic [23:0] prev_l, prev_r;

  always #5 clk = ~clk;

  serial_audio_rx u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_i2s_i(fmt), .bclk_i(bclk), .lrck_i(lrck),
    .sdata_i(sdata), .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .frame_err_o(frame_err_o), .short16_o(short16_o), .half_bits_o(half_bits_o)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic add_half(bit lvl, int n, int len, bit f, logic [23:0] s);
    for (int k = 0; k < n; k++) begin
      ent_t e;
      int idx;
      e.lvl = lvl;
      idx = f ? k : k - (n - len);
      e.d = (idx >= 0 && idx < len) ? s[23-idx] : k[0];
      ents.push_back(e);
    end
  endtask

  task automatic add_frame(bit f, int nl, int nr, logic [23:0] sl, logic [23:0] sr, string tag);
    exp_t x;
    int len;
    logic [23:0] m;
    bit ll;
    len = (nl == 16 && nr == 16) ? 16 : (f ? 24 : 20);
    ll = f ? 1'b0 : 1'b1;
    add_half(ll, nl, len, f, sl);
    add_half(~ll, nr, len, f, sr);
    m = 24'hFFFFFF << (24 - len);
    x.err = (nl < len) || (nr < len);
    x.l = x.err ? prev_l : (sl & m);
    x.r = x.err ? prev_r : (sr & m);
    x.sh = (len == 16);
    x.hb = (nr > 255) ? 255 : nr;
    x.tag = tag;
    if (!x.err) begin prev_l = x.l; prev_r = x.r; end
    sb.push_back(x);
  endtask

  task automatic play(bit f);
    for (int i = 0; i < ents.size(); i++) begin
      @(negedge clk);
      bclk = 1'b0;
      lrck = f ? ((i + 1 < ents.size()) ? ents[i+1].lvl : ents[i].lvl) : ents[i].lvl;
      sdata = ents[i].d;
      repeat (2) @(negedge clk);
      sdata = ~sdata;  // R1: toggles away from the rising edge are ignored
      repeat (2) @(negedge clk);
      sdata = ents[i].d;
      bclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    ents.delete();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (valid_o || frame_err_o)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected strobe", {31'd0, valid_o}, 32'd0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        check(frame_err_o == x.err, {x.tag, " R6 error strobe"}, {31'd0, frame_err_o}, {31'd0, x.err});
        check(left_o == x.l, {x.tag, " left word"}, {8'd0, left_o}, {8'd0, x.l});
        check(right_o == x.r, {x.tag, " right word"}, {8'd0, right_o}, {8'd0, x.r});
        check(32'(half_bits_o) == x.hb, {x.tag, " R8 half count"}, {24'd0, half_bits_o}, x.hb);
        if (!x.err)
          check(short16_o == x.sh, {x.tag, " R4 short flag"}, {31'd0, short16_o}, {31'd0, x.sh});
      end
    end
  end

  task automatic run(bit f);
    bit ll;
    ll = f ? 1'b0 : 1'b1;
    rst_n = 1'b0; fmt = f; bclk = 1'b0; lrck = 1'b0; sdata = 1'b0;
    prev_l = '0; prev_r = '0;
    repeat (4) @(negedge clk);
    check(left_o == 0 && right_o == 0, "R9 reset words", {8'd0, left_o}, 32'd0);
    check(!valid_o && !frame_err_o, "R9 reset strobes", {30'd0, valid_o, frame_err_o}, 32'd0);
    check(half_bits_o == 0, "R9 reset count", {24'd0, half_bits_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    add_half(~ll, 3, 3, f, 24'h0);        // R9 partial half before first toggle
    add_half(~ll, 0, 0, f, 24'h0);
    if (!f) begin
      add_frame(f, 20, 20, 24'hA5C3F0, 24'h3C5A90, "R2 rj basic");
      add_frame(f, 32, 24, 24'h123450, 24'hFEDCB0, "R5 R2 rj asym");
      add_frame(f, 16, 16, 24'hBEEF00, 24'h8001AB, "R4 rj short16");
      add_frame(f, 16, 17, 24'h111111, 24'h222222, "R10 R6 rj one16");
      add_frame(f, 20, 19, 24'h333333, 24'h444444, "R6 rj short right");
      add_frame(f, 21, 20, 24'h5A5A5A, 24'hC3C3C3, "R2 rj tail");
    end else begin
      add_frame(f, 24, 24, 24'hA5C3F1, 24'h3C5A97, "R3 i2s basic");
      add_frame(f, 30, 25, 24'h123457, 24'hFEDCBA, "R5 R3 i2s asym");
      add_frame(f, 16, 16, 24'hBEEF55, 24'h8001AB, "R4 i2s short16");
      add_frame(f, 24, 300, 24'h0F0F0F, 24'hF0F0F1, "R8 i2s saturate");
      add_frame(f, 20, 24, 24'h777777, 24'h888888, "R6 i2s short left");
      add_frame(f, 24, 24, 24'h000001, 24'h800000, "R3 i2s edges");
    end
    add_half(ll, 4, 4, f, 24'h0);
    play(f);
    repeat (60) @(negedge clk);
    check(sb.size() == 0, "R7 all frames strobed", sb.size(), 32'd0);
    sb.delete();
  endtask

  initial begin
    run(1'b0);
    run(1'b1);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule